// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits between a simple word-wide register port and an 8-bit NAND flash bus with one chip select. Software writes a command byte, an address byte or a data byte to one of three registers, and each write becomes one bus cycle. A read of the data register launches one read strobe and hands back the byte taken from the bus. Every cycle passes through four phases: setup, strobe, hold and a ready-wait. The length of each phase in clocks comes from a packed timing word, and read cycles and write cycles have their own set of fields.

Beyond the cycle engine, the block shows the synchronized ready/busy pin in a status word. It raises a ready flag on each rising edge of that pin and a terminal-count flag when a programmed byte count runs out. The flags are cleared by writing ones and are masked onto one interrupt output. A configuration bit can hold chip enable low between cycles. While a cycle is running, a busy output tells the register master to hold its request, and any request made during that time is dropped.

Top module: `nand_cycle_seq`

## Requirements
- R1: The timing word (index 10) holds eight 4-bit fields. Bits [3:0], [7:4], [11:8] and [15:12] are the read setup, hold, strobe width and ready-wait. Bits [19:16], [23:20], [27:24] and [31:28] are the same four phases for write cycles. Each phase lasts field clocks, and a field of 0 lasts 1 clock.
- R2: A write to index 2 runs a write cycle. CLE is high from setup through hold, ALE stays low, and the low byte of the written value is driven on the bus with the output enable high during the strobe.
- R3: A write to index 1 runs the same kind of cycle with ALE high and CLE low.
- R4: A write to index 0 runs a write cycle with CLE and ALE both low. A read of index 0 runs a cycle with RE# low for the strobe and the output enable low. It returns the bus byte, zero-extended, with reg_rvalid high in the first idle clock after the cycle.
- R5: Chip enable is low from setup through hold and high otherwise. When config bit 5 (index 5) is set, chip enable stays low at all times.
- R6: reg_busy stays high for setup+strobe+hold+ready-wait clocks, counted after R1's rule for 0. After that it stays high until the synchronized ready pin reads 1.
- R7: A register request made while reg_busy is high is ignored.
- R8: Status word bit 0 (index 6) shows the ready pin after SYNC_STAGES clocks, with 1 meaning ready.
- R9: Interrupt flag bit 0 (index 7) sets on a rising edge of the synchronized ready pin. Writing ones to index 9 clears the matching flags. The interrupt enable register (index 8) gates each flag onto irq.
- R10: The transfer count (index 11) drops by one at each data cycle while it is nonzero. When it steps from 1 to 0, flag bit 1 sets. Command and address cycles leave it unchanged, and at zero it stays at zero.
- R11: Writing control bit 2 (index 4) returns the configuration, timing, enable, count and flag registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | DATA_W | Write value |
| reg_busy | output | 1 | Bus cycle in progress; requests are ignored |
| reg_rdata | output | DATA_W | Read value |
| reg_rvalid | output | 1 | Read value valid, one clock |
| irq | output | 1 | Enabled flags ORed |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus data output enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rdy | input | 1 | Device ready/busy pin, 1 = ready |

## Verification
The bench sweeps every combination of the values 0, 1, 2 and 15 in all four write fields, and then in all four read fields. In each pass the other half of the timing word is filled with ones. A design that mishandles the zero case, reads a field from the wrong position, or takes read timing from the write half measures a wrong phase length. The ready-wait is tested with the ready pin held low. A sequencer that ignored the pin would drop busy early, and a synchronizer reset to 0 would raise a false ready flag. Other tests cover a write made during busy, the transfer count reaching zero and sitting at zero, and the software reset.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_RWAIT
   } phase_e;

   typedef enum logic [1:0] {
      OP_CMD,
      OP_ADR,
      OP_DAT
   } op_kind_e;

   typedef struct packed {
      logic     rd;
      op_kind_e kind;
      logic [7:0] dat;
   } op_req_t;

   // register word indices
   localparam int unsigned RIX_DATA   = 0;
   localparam int unsigned RIX_ADDR   = 1;
   localparam int unsigned RIX_CMD    = 2;
   localparam int unsigned RIX_CTRL   = 4;
   localparam int unsigned RIX_CFG    = 5;
   localparam int unsigned RIX_STAT   = 6;
   localparam int unsigned RIX_IFLAG  = 7;
   localparam int unsigned RIX_IEN    = 8;
   localparam int unsigned RIX_ICLR   = 9;
   localparam int unsigned RIX_TIMING = 10;
   localparam int unsigned RIX_TCNT   = 11;

   // bit positions software depends on
   localparam int unsigned CFG_FORCE_CE_BIT = 5;
   localparam int unsigned CTRL_SWRST_BIT   = 2;
   localparam int unsigned NFLAGS           = 2;

   // field slot inside one half of the timing word
   localparam int unsigned SLOT_SETUP = 0;
   localparam int unsigned SLOT_HOLD  = 1;
   localparam int unsigned SLOT_WIDTH = 2;
   localparam int unsigned SLOT_RWAIT = 3;
   localparam int unsigned WR_HALF_BASE = 4;

endpackage

// File: rtl/nand_rdy_sync.sv
module nand_rdy_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '1;
            else        ff <= (ff << 1) | STAGES'(d);
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
   import nand_seq_pkg::*;
#(
   parameter int unsigned PHASE_W = 4,
   localparam int unsigned TMG_W  = 8 * PHASE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  op_req_t          op,
   input  logic [TMG_W-1:0] tmg,
   input  logic             rdy_s,
   input  logic [7:0]       dq_i,
   output logic             busy,
   output logic             active,
   output logic             done,
   output logic [7:0]       rbyte,
   output logic             cle,
   output logic             ale,
   output logic             we_n,
   output logic             re_n,
   output logic             dq_oe,
   output logic [7:0]       dq_o
);
   phase_e                  st;
   logic [PHASE_W-1:0]      cnt;
   op_req_t                 op_q;
   logic [2:0][PHASE_W-1:0] len_q;   // 0 hold, 1 width, 2 ready-wait (already minus one)
   int unsigned             base_idx;

   function automatic logic [PHASE_W-1:0] minus1(input logic [PHASE_W-1:0] v);
      return (v == '0) ? '0 : v - 1'b1;
   endfunction

   always_comb base_idx = op.rd ? 0 : WR_HALF_BASE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= PH_IDLE;
         cnt   <= '0;
         op_q  <= '0;
         len_q <= '0;
         rbyte <= '0;
      end else begin
         case (st)
            PH_IDLE: if (start) begin
               op_q     <= op;
               len_q[0] <= minus1(tmg[(base_idx + SLOT_HOLD)  * PHASE_W +: PHASE_W]);
               len_q[1] <= minus1(tmg[(base_idx + SLOT_WIDTH) * PHASE_W +: PHASE_W]);
               len_q[2] <= minus1(tmg[(base_idx + SLOT_RWAIT) * PHASE_W +: PHASE_W]);
               cnt      <= minus1(tmg[(base_idx + SLOT_SETUP) * PHASE_W +: PHASE_W]);
               st       <= PH_SETUP;
            end
            PH_SETUP: if (cnt == '0) begin
               st  <= PH_STROBE;
               cnt <= len_q[1];
            end else cnt <= cnt - 1'b1;
            PH_STROBE: if (cnt == '0) begin
               st  <= PH_HOLD;
               cnt <= len_q[0];
               if (op_q.rd) rbyte <= dq_i;
            end else cnt <= cnt - 1'b1;
            PH_HOLD: if (cnt == '0) begin
               st  <= PH_RWAIT;
               cnt <= len_q[2];
            end else cnt <= cnt - 1'b1;
            PH_RWAIT: if (cnt != '0) cnt <= cnt - 1'b1;
                      else if (rdy_s) st <= PH_IDLE;
            default: st <= PH_IDLE;
         endcase
      end
   end

   assign busy   = (st != PH_IDLE);
   assign active = (st == PH_SETUP) || (st == PH_STROBE) || (st == PH_HOLD);
   assign done   = (st == PH_RWAIT) && (cnt == '0) && rdy_s;
   assign cle    = active && (op_q.kind == OP_CMD);
   assign ale    = active && (op_q.kind == OP_ADR);
   assign we_n   = !((st == PH_STROBE) && !op_q.rd);
   assign re_n   = !((st == PH_STROBE) && op_q.rd);
   assign dq_oe  = active && !op_q.rd;
   assign dq_o   = op_q.dat;

   assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   assert_cle_ale_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   assert_rwait_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == PH_RWAIT && st == PH_IDLE) |-> $past(rdy_s));
endmodule

// File: rtl/nand_irq_ctl.sv
module nand_irq_ctl
   import nand_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              rdy_s,
   input  logic              tc_hit,
   input  logic              clr_we,
   input  logic [NFLAGS-1:0] clr_bits,
   input  logic [NFLAGS-1:0] en,
   output logic [NFLAGS-1:0] flags,
   output logic              irq
);
   logic              rdy_d;
   logic              rise;
   logic [NFLAGS-1:0] set_v;
   logic [NFLAGS-1:0] clr_v;

   assign rise  = rdy_s && !rdy_d;
   assign set_v = {tc_hit, rise};
   assign clr_v = clr_we ? clr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_d <= 1'b1;
         flags <= '0;
      end else begin
         rdy_d <= rdy_s;
         if (sw_rst) flags <= '0;
         else        flags <= (flags & ~clr_v) | set_v;
      end
   end

   assign irq = |(flags & en);

   assert_rdy_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(rise));
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
   import nand_seq_pkg::*;
#(
   parameter int unsigned PHASE_W     = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned TC_W        = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic              reg_busy,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_rvalid,
   output logic              irq,
   output logic              nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [7:0]        nand_dq_o,
   output logic              nand_dq_oe,
   input  logic [7:0]        nand_dq_i,
   input  logic              nand_rdy
);
   localparam int unsigned TMG_W = 8 * PHASE_W;

   generate
      if (DATA_W < TMG_W || DATA_W < TC_W || DATA_W < 8)
         $error("DATA_W too narrow for timing word or count");
      if (ADDR_W < 4)
         $error("ADDR_W must reach register index 11");
      if (PHASE_W < 1)
         $error("PHASE_W must be at least 1");
   endgenerate

   logic              busy, active, done, rdy_s, irq_w;
   logic [7:0]        rbyte;
   logic              acc_wr, acc_rd, start, sw_rst, pend_rd, tc_hit;
   op_req_t           op;
   logic              force_ce;
   logic [TMG_W-1:0]  timing_q;
   logic [NFLAGS-1:0] ien_q, flags;
   logic [TC_W-1:0]   tc_cnt;
   logic [DATA_W-1:0] rd_mux;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned idx);
      return a == ADDR_W'(idx);
   endfunction

   assign acc_wr = reg_wr && !busy;
   assign acc_rd = reg_rd && !reg_wr && !busy;
   assign start  = (acc_wr && (hit(reg_addr, RIX_DATA) || hit(reg_addr, RIX_ADDR) ||
                               hit(reg_addr, RIX_CMD)))
                 || (acc_rd && hit(reg_addr, RIX_DATA));
   assign sw_rst = acc_wr && hit(reg_addr, RIX_CTRL) && reg_wdata[CTRL_SWRST_BIT];
   assign tc_hit = start && (op.kind == OP_DAT) && (tc_cnt == TC_W'(1));

   always_comb begin
      op.rd   = acc_rd;
      op.dat  = reg_wdata[7:0];
      if (hit(reg_addr, RIX_CMD))       op.kind = OP_CMD;
      else if (hit(reg_addr, RIX_ADDR)) op.kind = OP_ADR;
      else                              op.kind = OP_DAT;
   end

   nand_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(nand_rdy), .q(rdy_s));

   nand_phase_fsm #(.PHASE_W(PHASE_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .tmg(timing_q),
      .rdy_s(rdy_s), .dq_i(nand_dq_i), .busy(busy), .active(active),
      .done(done), .rbyte(rbyte), .cle(nand_cle), .ale(nand_ale),
      .we_n(nand_we_n), .re_n(nand_re_n), .dq_oe(nand_dq_oe), .dq_o(nand_dq_o));

   nand_irq_ctl u_irq (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .rdy_s(rdy_s), .tc_hit(tc_hit),
      .clr_we(acc_wr && hit(reg_addr, RIX_ICLR)), .clr_bits(reg_wdata[NFLAGS-1:0]),
      .en(ien_q), .flags(flags), .irq(irq_w));

   // configuration registers and transfer count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_ce <= 1'b0;
         timing_q <= '0;
         ien_q    <= '0;
         tc_cnt   <= '0;
      end else if (sw_rst) begin
         force_ce <= 1'b0;
         timing_q <= '0;
         ien_q    <= '0;
         tc_cnt   <= '0;
      end else begin
         if (acc_wr && hit(reg_addr, RIX_CFG))    force_ce <= reg_wdata[CFG_FORCE_CE_BIT];
         if (acc_wr && hit(reg_addr, RIX_TIMING)) timing_q <= reg_wdata[TMG_W-1:0];
         if (acc_wr && hit(reg_addr, RIX_IEN))    ien_q    <= reg_wdata[NFLAGS-1:0];
         if (acc_wr && hit(reg_addr, RIX_TCNT))   tc_cnt   <= reg_wdata[TC_W-1:0];
         else if (start && op.kind == OP_DAT && tc_cnt != '0) tc_cnt <= tc_cnt - 1'b1;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (hit(reg_addr, RIX_CFG))         rd_mux = DATA_W'(force_ce) << CFG_FORCE_CE_BIT;
      else if (hit(reg_addr, RIX_STAT))   rd_mux = DATA_W'(rdy_s);
      else if (hit(reg_addr, RIX_IFLAG))  rd_mux = DATA_W'(flags);
      else if (hit(reg_addr, RIX_IEN))    rd_mux = DATA_W'(ien_q);
      else if (hit(reg_addr, RIX_TIMING)) rd_mux = DATA_W'(timing_q);
      else if (hit(reg_addr, RIX_TCNT))   rd_mux = DATA_W'(tc_cnt);
   end

   // read return path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rvalid <= 1'b0;
         reg_rdata  <= '0;
         pend_rd    <= 1'b0;
      end else begin
         reg_rvalid <= 1'b0;
         if (acc_rd && !hit(reg_addr, RIX_DATA)) begin
            reg_rvalid <= 1'b1;
            reg_rdata  <= rd_mux;
         end
         if (start && acc_rd) pend_rd <= 1'b1;
         if (done && pend_rd) begin
            pend_rd    <= 1'b0;
            reg_rvalid <= 1'b1;
            reg_rdata  <= DATA_W'(rbyte);
         end
      end
   end

   assign reg_busy  = busy;
   assign irq       = irq_w;
   assign nand_ce_n = !(active || force_ce);

   assert_ce_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
   assert_tc_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> ($past(tc_cnt) == TC_W'(1)));
   assert_swrst_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sw_rst) |-> (!force_ce && timing_q == '0 && flags == '0 && tc_cnt == '0));
   assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_wr && busy && hit(reg_addr, RIX_TCNT)) |-> $stable(tc_cnt));
endmodule

// File: tb/sim_nand_cycle_seq.sv
module sim_nand_cycle_seq;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        reg_wr = 0, reg_rd = 0;
   logic [3:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic        reg_busy, reg_rvalid, irq;
   logic [31:0] reg_rdata;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]  nand_dq_o;
   logic [7:0]  nand_dq_i = 0;
   logic        nand_rdy = 1;

   int checks = 0, fails = 0, cyc = 0;
   int m_busy, m_setup, m_strobe, m_hold, m_wait;
   logic [10:0] m_snap;   // {cle, ale, oe, dq}
   logic [31:0] v;

   always #10 clk = ~clk;   // 50 MHz

   nand_cycle_seq u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_busy(reg_busy), .reg_rdata(reg_rdata),
      .reg_rvalid(reg_rvalid), .irq(irq), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
      .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
      .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
      .nand_rdy(nand_rdy));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL R6 watchdog act=hung exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic int eff(input int x);
      return (x == 0) ? 1 : x;
   endfunction

   task automatic launch(input int a, input logic rd, input logic [31:0] d);
      int g = 0;
      while (reg_busy && g < 5000) begin @(negedge clk); g++; end
      reg_addr = 4'(a); reg_wr = !rd; reg_rd = rd; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 0; reg_rd = 0;
   endtask

   task automatic measure();
      int g = 0;
      logic seen = 0;
      m_busy = 0; m_setup = 0; m_strobe = 0; m_hold = 0; m_wait = 0; m_snap = '0;
      while (reg_busy && g < 2000) begin
         m_busy++;
         if (!nand_ce_n) begin
            if (!nand_we_n || !nand_re_n) begin
               m_strobe++;
               if (!seen) m_snap = {nand_cle, nand_ale, nand_dq_oe, nand_dq_o};
               seen = 1;
            end else if (!seen) m_setup++;
            else m_hold++;
         end else m_wait++;
         @(negedge clk);
         g++;
      end
   endtask

   task automatic wreg(input int a, input logic [31:0] d);
      launch(a, 0, d); measure();
   endtask

   task automatic rreg(input int a, output logic [31:0] d);
      launch(a, 1, 0); measure(); d = reg_rdata;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk("R5 reset ce_n", nand_ce_n, 1);
      chk("R4 reset strobes", {nand_we_n, nand_re_n, nand_cle, nand_ale}, 4'b1100);
      chk("R6 reset busy", reg_busy, 0);
      chk("R9 reset irq", irq, 0);
      rreg(7, v); chk("R9 reset flags", v, 0);
      rreg(10, v); chk("R1 reset timing", v, 0);
      rreg(6, v); chk("R8 reset status", v, 1);

      // write-cycle sweep: fields over {0,1,2,15}
      for (int n = 0; n < 256; n++) begin
         int s, h, w, r, kind, a;
         logic [7:0] b;
         logic [10:0] exp;
         s = (n % 4 == 3) ? 15 : n % 4;
         h = ((n / 4) % 4 == 3) ? 15 : (n / 4) % 4;
         w = ((n / 16) % 4 == 3) ? 15 : (n / 16) % 4;
         r = ((n / 64) % 4 == 3) ? 15 : (n / 64) % 4;
         wreg(10, {4'(r), 4'(w), 4'(h), 4'(s), 16'hFFFF});
         kind = n % 3;
         a = (kind == 0) ? 2 : (kind == 1) ? 1 : 0;
         b = 8'(n * 13 + 5);
         wreg(a, {24'hABCDEF, b});
         chk("R1 write setup", m_setup, eff(s));
         chk("R1 write width", m_strobe, eff(w));
         chk("R1 write hold", m_hold, eff(h));
         chk("R6 write ready-wait", m_wait, eff(r));
         exp = {kind == 0, kind == 1, 1'b1, b};
         if (kind == 0)      chk("R2 cmd cycle pins", m_snap, exp);
         else if (kind == 1) chk("R3 addr cycle pins", m_snap, exp);
         else                chk("R4 data write pins", m_snap, exp);
      end

      // read-cycle sweep
      for (int n = 0; n < 256; n++) begin
         int s, h, w, r;
         logic [7:0] b;
         s = (n % 4 == 3) ? 15 : n % 4;
         h = ((n / 4) % 4 == 3) ? 15 : (n / 4) % 4;
         w = ((n / 16) % 4 == 3) ? 15 : (n / 16) % 4;
         r = ((n / 64) % 4 == 3) ? 15 : (n / 64) % 4;
         wreg(10, {16'hFFFF, 4'(r), 4'(w), 4'(h), 4'(s)});
         b = 8'(n * 29 + 11);
         nand_dq_i = b;
         launch(0, 1, 0); measure();
         chk("R1 read setup", m_setup, eff(s));
         chk("R1 read width", m_strobe, eff(w));
         chk("R1 read hold", m_hold, eff(h));
         chk("R6 read ready-wait", m_wait, eff(r));
         chk("R4 read return", {reg_rvalid, reg_rdata}, {1'b1, 24'h0, b});
         chk("R4 read no drive", {m_snap[10:8]}, 3'b000);
      end

      // forced chip enable
      wreg(10, 0);
      wreg(5, 32'h20);
      chk("R5 force ce idle", nand_ce_n, 0);
      rreg(5, v); chk("R5 cfg readback", v, 32'h20);
      wreg(2, 32'h90);
      chk("R5 force ce through wait", m_wait, 0);
      chk("R5 force ce still low", nand_ce_n, 0);
      wreg(5, 0);
      chk("R5 ce released", nand_ce_n, 1);

      // request during busy ignored
      wreg(10, 32'hFFFF_FFFF);
      launch(2, 0, 32'hA5);
      reg_addr = 4'd11; reg_wr = 1; reg_wdata = 32'h55;
      @(negedge clk);
      reg_wr = 0;
      measure();
      rreg(11, v); chk("R7 write during busy dropped", v, 0);

      // ready pin, status and ready-wait stall
      wreg(10, 0);
      nand_rdy = 0;
      repeat (4) @(negedge clk);
      rreg(6, v); chk("R8 status not ready", v, 0);
      launch(2, 0, 32'h70);
      repeat (20) @(negedge clk);
      chk("R6 stalls while not ready", reg_busy, 1);
      nand_rdy = 1;
      repeat (4) @(negedge clk);
      chk("R6 finishes once ready", reg_busy, 0);
      rreg(6, v); chk("R8 status ready", v, 1);
      rreg(7, v); chk("R9 ready flag set", v, 1);
      chk("R9 masked irq", irq, 0);
      wreg(8, 1);
      chk("R9 enabled irq", irq, 1);
      wreg(9, 1);
      rreg(7, v); chk("R9 flag cleared", v, 0);
      chk("R9 irq after clear", irq, 0);

      // transfer count
      wreg(11, 3);
      for (int k = 1; k <= 3; k++) begin
         wreg(0, 32'(k));
         rreg(11, v); chk("R10 count step", v, 32'(3 - k));
         rreg(7, v); chk("R10 tc flag", v[1], (k == 3) ? 1 : 0);
      end
      wreg(11, 2);
      wreg(2, 32'hFF);
      wreg(1, 32'h00);
      rreg(11, v); chk("R10 cmd/addr keep count", v, 2);
      wreg(11, 0);
      wreg(0, 32'h12);
      rreg(11, v); chk("R10 zero holds", v, 0);
      wreg(8, 2);
      chk("R9 tc irq", irq, 1);
      wreg(9, 3);
      chk("R9 tc cleared irq", irq, 0);

      // software reset
      wreg(5, 32'h20);
      wreg(8, 3);
      wreg(10, 32'h1234_5678);
      wreg(11, 9);
      wreg(4, 32'h4);
      rreg(5, v);  chk("R11 cfg cleared", v, 0);
      rreg(8, v);  chk("R11 enable cleared", v, 0);
      rreg(10, v); chk("R11 timing cleared", v, 0);
      rreg(11, v); chk("R11 count cleared", v, 0);
      chk("R11 ce released", nand_ce_n, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule